// File: doc/BRIEF.md
# UART register front end with repacked word map

This block is the bus-facing half of a 16550-style UART whose registers sit on a 32-bit, word-addressed bus. The byte address of each register is its index shifted left by two, and only full-word accesses are meaningful. The block decodes the bus and holds the interrupt enable, line control, modem control and FIFO control settings, plus the baud divisor. It owns a transmit FIFO and a receive FIFO of equal depth, and it produces the baud tick for the serial engines.

The register map is rearranged compared with the classic part. There is no divisor latch access bit, and the divisor has its own word. Line control and modem control share one word. FIFO control is written at index 3. The transmit and receive shift engines sit outside the block. They attach through a valid/ready byte stream in the transmit direction and a valid-only byte stream in the receive direction. The receive side is valid-only because a serial line cannot be stalled. The engines also take the baud tick and the control fields from the block's outputs.

Top module: `uart_regfront`

## Requirements
- R1: A bus write to index 0 pushes `bus_wdata[7:0]` into the transmit FIFO. The transmit port offers the stored bytes in write order, with `tx_valid` high while the FIFO holds data, and it hands over one byte each cycle in which `tx_valid` and `tx_ready` are both high.
- R2: A bus read at index 0 returns the oldest receive byte in bits 7:0, with zeros above, and removes it from the FIFO. A read at index 0 with the receive FIFO empty returns 0 and changes nothing. A byte is pushed into the receive FIFO in every cycle in which `rx_valid` is high.
- R3: Index 4 holds modem control in bits 7:0 and line control in bits 15:8. One write to index 4 updates both fields from the write data in the same cycle. Bits 31:16 are ignored on write and read as 0. The `line_ctrl` and `modem_ctrl` outputs show the stored fields.
- R4: Line control bit 7 (word bit 15) is never stored. It reads back as 0 and appears as 0 on `line_ctrl[7]`.
- R5: The baud divisor is read and written directly at index 9, in bits DIV_W-1:0. No other register and no line control bit affects access to it.
- R6: A write to index 3 with bit 1 set empties the receive FIFO, and a write with bit 2 set empties the transmit FIFO. Bits 1 and 2 read back as 0. Bit 0 is stored and drives `fifo_enable`. A write to index 2 leaves both FIFOs untouched.
- R7: Each FIFO holds FIFO_DEPTH (64) bytes. A push into a full FIFO that is not popped in the same cycle is dropped and sets the overrun flag. A push into a full FIFO in a cycle in which that FIFO is popped is accepted.
- R8: A read at index 5 returns line status: bit 0 means the receive FIFO is not empty, bit 1 is the overrun flag, bit 5 means the transmit FIFO is empty, and all other bits are 0. Reading index 5 clears the overrun flag. If a new overrun occurs in the same cycle as the read, the flag stays set.
- R9: With a non-zero divisor D, `baud_tick` pulses for one cycle every D cycles. The count restarts whenever the divisor is written. With D = 0 there is no tick.
- R10: Index 1 stores the interrupt enable byte from bits 7:0. It reads back at index 1 and drives `irq_enable`.
- R11: After reset, all stored registers are 0, both FIFOs are empty, line status reads 0x20 and `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; the register index is bits ADDR_W-1:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| tx_valid | output | 1 | Transmit FIFO has a byte for the engine |
| tx_data | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Transmit engine takes the byte |
| rx_valid | input | 1 | Receive engine delivers a byte |
| rx_data | input | 8 | Received byte |
| baud_tick | output | 1 | One-cycle pulse every divisor cycles |
| line_ctrl | output | 8 | Stored line control (bit 7 always 0) |
| modem_ctrl | output | 8 | Stored modem control |
| irq_enable | output | 8 | Stored interrupt enable |
| fifo_enable | output | 1 | FIFO enable bit from FIFO control |

## Verification
Two functions can coincide in one cycle, and the bench drives both of them on purpose. In the first case, the receive engine delivers a byte while the bus pops a full receive FIFO. The byte must be accepted with no overrun, and it must come out last when the FIFO is drained. In the second case, a push into a full receive FIFO lands in the same cycle as a line status read. That read must still return the old, clear overrun bit, the following read must show the flag set, and the read after that must show it cleared.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

  // Word indices of the register map
  localparam int IX_DATA  = 0;
  localparam int IX_IEN   = 1;
  localparam int IX_IIR   = 2;
  localparam int IX_FIFO  = 3;
  localparam int IX_LNMD  = 4;
  localparam int IX_LSTAT = 5;
  localparam int IX_DIV   = 9;

  // Field positions inside the shared line/modem word
  localparam int LC_LSB = 8;
  localparam int MC_LSB = 0;

  // FIFO control bit positions
  localparam int FC_EN    = 0;
  localparam int FC_RXCLR = 1;
  localparam int FC_TXCLR = 2;

  // Line status bit positions
  localparam int LS_RXNE = 0;
  localparam int LS_OVR  = 1;
  localparam int LS_TXMT = 5;

  // Line control as stored: bit 7 has no storage
  function automatic logic [7:0] line_from_word(input logic [31:0] w);
    return {1'b0, w[LC_LSB+6:LC_LSB]};
  endfunction

  function automatic logic [31:0] pack_line_modem(input logic [7:0] lc,
                                                  input logic [7:0] mc);
    logic [31:0] w;
    w = '0;
    w[LC_LSB+7:LC_LSB] = lc;
    w[MC_LSB+7:MC_LSB] = mc;
    return w;
  endfunction

  function automatic logic [7:0] lstat_byte(input logic rx_ne,
                                            input logic ovr,
                                            input logic tx_mt);
    logic [7:0] b;
    b = '0;
    b[LS_RXNE] = rx_ne;
    b[LS_OVR]  = ovr;
    b[LS_TXMT] = tx_mt;
    return b;
  endfunction

  // FIFO control as stored: the self-clearing bits are dropped
  function automatic logic [7:0] fifo_ctrl_store(input logic [7:0] v);
    logic [7:0] b;
    b = v;
    b[FC_RXCLR] = 1'b0;
    b[FC_TXCLR] = 1'b0;
    return b;
  endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         drop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          pop_ok, push_ok;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_FULL);
  assign pop_ok  = pop && !empty && !clr;
  assign push_ok = push && !clr && (!full || pop_ok);
  assign drop    = push && !clr && full && !pop_ok;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: occupancy never exceeds the depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL);
  // R7: a dropped push leaves the FIFO full
  a_r7_drop_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> full);
  // R7: push and pop together on a full FIFO keep it full
  a_r7_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop && !clr) |=> full);
  // R6: a clear leaves the FIFO empty
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);

endmodule

// File: rtl/uart_baud_ticker.sv
module uart_baud_ticker #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  // Counter step: reload from the divisor after the last cycle of a period
  function automatic logic [DIV_W-1:0] cnt_next(input logic [DIV_W-1:0] c,
                                                input logic [DIV_W-1:0] d);
    if (d == '0)                return '0;
    if (c == '0 || c == DIV_W'(1)) return d;
    return c - 1'b1;
  endfunction

  assign tick = (divisor != '0) && (cnt == DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= cnt_next(cnt, divisor);
  end

  // R9: no tick with a zero divisor
  a_r9_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> !tick);
  // R9: ticks are spaced apart unless the divisor is one
  a_r9_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor > DIV_W'(1)) |=> !tick);
  // R9: a restart suppresses the tick in the next cycle
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int FIFO_DEPTH = 64,
  parameter int DIV_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              baud_tick,
  output logic [7:0]        line_ctrl,
  output logic [7:0]        modem_ctrl,
  output logic [7:0]        irq_enable,
  output logic              fifo_enable
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0]    idx;
  logic             rd_acc, wr_acc;
  logic [7:0]       ien_q, lc_q, mc_q, fc_q;
  logic [DIV_W-1:0] div_q;
  logic             ovr_q;

  // Named internal events
  logic ev_tx_push, ev_rx_pop, ev_lstat_rd, ev_lnmd_wr;
  logic ev_fifo_wr, ev_div_wr, ev_ien_wr, ev_rx_clr, ev_tx_clr;
  logic rx_drop, tx_drop;
  logic rx_empty, rx_full, tx_empty, tx_full;
  logic [7:0] rx_head;

  assign idx    = bus_addr[ADDR_W-1:2];
  assign rd_acc = bus_sel && !bus_wr;
  assign wr_acc = bus_sel && bus_wr;

  assign ev_tx_push  = wr_acc && (idx == IW'(IX_DATA));
  assign ev_rx_pop   = rd_acc && (idx == IW'(IX_DATA));
  assign ev_lstat_rd = rd_acc && (idx == IW'(IX_LSTAT));
  assign ev_ien_wr   = wr_acc && (idx == IW'(IX_IEN));
  assign ev_lnmd_wr  = wr_acc && (idx == IW'(IX_LNMD));
  assign ev_fifo_wr  = wr_acc && (idx == IW'(IX_FIFO));
  assign ev_div_wr   = wr_acc && (idx == IW'(IX_DIV));
  assign ev_rx_clr   = ev_fifo_wr && bus_wdata[FC_RXCLR];
  assign ev_tx_clr   = ev_fifo_wr && bus_wdata[FC_TXCLR];

  uart_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ev_tx_clr),
    .push      (ev_tx_push),
    .push_data (bus_wdata[7:0]),
    .pop       (tx_valid && tx_ready),
    .head      (tx_data),
    .empty     (tx_empty),
    .full      (tx_full),
    .drop      (tx_drop)
  );

  uart_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ev_rx_clr),
    .push      (rx_valid),
    .push_data (rx_data),
    .pop       (ev_rx_pop),
    .head      (rx_head),
    .empty     (rx_empty),
    .full      (rx_full),
    .drop      (rx_drop)
  );

  uart_baud_ticker #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .divisor (div_q),
    .restart (ev_div_wr),
    .tick    (baud_tick)
  );

  assign tx_valid = !tx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      lc_q  <= '0;
      mc_q  <= '0;
      fc_q  <= '0;
      div_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (ev_ien_wr) ien_q <= bus_wdata[7:0];
      if (ev_lnmd_wr) begin
        lc_q <= line_from_word(bus_wdata);
        mc_q <= bus_wdata[MC_LSB+7:MC_LSB];
      end
      if (ev_fifo_wr) fc_q  <= fifo_ctrl_store(bus_wdata[7:0]);
      if (ev_div_wr)  div_q <= bus_wdata[DIV_W-1:0];
      if (rx_drop || tx_drop) ovr_q <= 1'b1;
      else if (ev_lstat_rd)   ovr_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      case (idx)
        IW'(IX_DATA):  bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
        IW'(IX_IEN):   bus_rdata = {24'd0, ien_q};
        IW'(IX_FIFO):  bus_rdata = {24'd0, fc_q};
        IW'(IX_LNMD):  bus_rdata = pack_line_modem(lc_q, mc_q);
        IW'(IX_LSTAT): bus_rdata = {24'd0, lstat_byte(!rx_empty, ovr_q, tx_empty)};
        IW'(IX_DIV):   bus_rdata = 32'(div_q);
        default:       bus_rdata = '0;
      endcase
    end
  end

  assign line_ctrl   = lc_q;
  assign modem_ctrl  = mc_q;
  assign irq_enable  = ien_q;
  assign fifo_enable = fc_q[FC_EN];

  // R3: one write updates both packed fields
  a_r3_pack_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lnmd_wr |=> (modem_ctrl == $past(bus_wdata[7:0])) &&
                   (line_ctrl[6:0] == $past(bus_wdata[14:8])));
  // R3: upper half of the shared word reads zero
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && idx == IW'(IX_LNMD)) |-> (bus_rdata[31:16] == 16'd0));
  // R4: no divisor latch access bit survives a write
  a_r4_no_dlab: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lnmd_wr |=> (line_ctrl[7] == 1'b0));
  // R5: divisor write lands directly
  a_r5_div_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_div_wr |=> (div_q == $past(bus_wdata[DIV_W-1:0])));
  // R8: any dropped push raises overrun
  a_r8_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop || tx_drop) |=> ovr_q);
  // R8: a status read with no new overrun clears it
  a_r8_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lstat_rd && !rx_drop && !tx_drop) |=> !ovr_q);
  // R6: self-clearing bits never read back
  a_r6_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && idx == IW'(IX_FIFO)) |-> (bus_rdata[2:1] == 2'b00));

endmodule

// File: tb/uart_regfront_bench.sv
module uart_regfront_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        baud_tick;
  logic [7:0]  line_ctrl, modem_ctrl, irq_enable;
  logic        fifo_enable;

  int n_chk = 0, n_fail = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  bit done = 0;

  always #10 clk = ~clk;

  uart_regfront u_uart_regfront (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .baud_tick(baud_tick),
    .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl), .irq_enable(irq_enable),
    .fifo_enable(fifo_enable)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic bus_write(int ix, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 6'(ix << 2); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(int ix, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 6'(ix << 2);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  // Read while the receive engine delivers a byte in the same cycle
  task automatic read_with_rx(int ix, logic [7:0] b, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 6'(ix << 2);
    rx_valid = 1; rx_data = b;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; rx_valid = 0;
  endtask

  // Driver: transmit byte, expected item queued if there is room
  task automatic tx_send(logic [7:0] b);
    if (tx_q.size() < 64) tx_q.push_back(b);
    bus_write(0, {24'hABCDEF, b});
  endtask

  task automatic rx_send(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic tick_period(output int p);
    for (int g = 0; g < 100; g++) begin
      @(negedge clk); #1;
      if (baud_tick) break;
    end
    p = 0;
    for (int g = 0; g < 100; g++) begin
      @(negedge clk); #1;
      p++;
      if (baud_tick) break;
    end
  endtask

  // Monitor: compares transmit handshakes against the scoreboard (R1)
  always begin
    @(negedge clk); #2;
    if (rst_n && tx_valid && tx_ready) begin
      if (tx_q.size() == 0) check("R1 unexpected tx byte", {24'd0, tx_data}, 32'hFFFFFFFF);
      else check("R1 tx order", {24'd0, tx_data}, {24'd0, tx_q.pop_front()});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int p, ticks;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    bus_read(5, d); check("R11 line status", d, 32'h20);
    bus_read(4, d); check("R11 line/modem", d, 0);
    bus_read(9, d); check("R11 divisor", d, 0);
    bus_read(1, d); check("R11 irq enable", d, 0);
    check("R11 tx_valid", {31'd0, tx_valid}, 0);

    // R10 interrupt enable
    bus_write(1, 32'hFFFF_FFA5);
    bus_read(1, d); check("R10 readback", d, 32'hA5);
    check("R10 port", {24'd0, irq_enable}, 32'hA5);

    // R3 packed word, R4 no DLAB
    bus_write(4, 32'hDEAD_3C5A);
    bus_read(4, d); check("R3 packed read", d, 32'h0000_3C5A);
    check("R3 line port", {24'd0, line_ctrl}, 32'h3C);
    check("R3 modem port", {24'd0, modem_ctrl}, 32'h5A);
    bus_write(4, 32'h0000_9B11);
    bus_read(4, d); check("R4 bit15 dropped", d, 32'h0000_1B11);
    check("R4 line port bit7", {24'd0, line_ctrl}, 32'h1B);

    // R5 divisor direct access
    bus_write(9, 32'h0000_1234);
    bus_write(4, 32'h0000_8000);
    bus_read(9, d); check("R5 divisor readback", d, 32'h1234);
    bus_read(4, d); check("R5 line/modem separate", d, 0);

    // R9 tick generation
    bus_write(9, 4);
    tick_period(p); check("R9 period div4", p, 4);
    bus_write(9, 1);
    tick_period(p); check("R9 period div1", p, 1);
    bus_write(9, 7);
    tick_period(p); check("R9 period div7", p, 7);
    bus_write(9, 0);
    ticks = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); #1; if (baud_tick) ticks++; end
    check("R9 zero divisor silent", ticks, 0);

    // R1 / R7 transmit fill and overflow
    tx_ready = 0;
    for (int i = 0; i < 66; i++) tx_send(8'(i * 7 + 3));
    check("R7 scoreboard depth", tx_q.size(), 64);
    bus_read(5, d); check("R7 tx overrun and not empty", d, 32'h02);
    bus_read(5, d); check("R8 overrun cleared by read", d, 32'h00);
    tx_ready = 1;
    repeat (80) @(negedge clk);
    check("R1 all tx bytes delivered", tx_q.size(), 0);
    bus_read(5, d); check("R8 tx empty", d, 32'h20);
    // pushes while draining
    for (int i = 0; i < 5; i++) tx_send(8'hC0 + 8'(i));
    repeat (10) @(negedge clk);
    check("R1 streaming drain", tx_q.size(), 0);

    // R2 receive pop
    rx_send(8'h11); rx_send(8'h22); rx_send(8'h33);
    bus_read(5, d); check("R8 rx not empty", d, 32'h21);
    bus_read(0, d); check("R2 first", d, 32'h11);
    bus_read(0, d); check("R2 second", d, 32'h22);
    bus_read(0, d); check("R2 third", d, 32'h33);
    bus_read(0, d); check("R2 empty read zero", d, 0);
    bus_read(5, d); check("R2 empty after pops", d, 32'h20);

    // R6 FIFO control
    tx_ready = 0;
    rx_send(8'h44); rx_send(8'h55);
    tx_send(8'h66); tx_send(8'h77);
    bus_write(2, 32'h06);
    bus_read(5, d); check("R6 index 2 no effect", d, 32'h01);
    bus_write(3, 32'h03);
    bus_read(5, d); check("R6 rx cleared only", d, 32'h00);
    bus_read(3, d); check("R6 self clear readback", d, 32'h01);
    check("R6 fifo enable", {31'd0, fifo_enable}, 1);
    bus_write(3, 32'h05);
    tx_q.delete();
    bus_read(5, d); check("R6 tx cleared", d, 32'h20);
    check("R6 tx_valid low", {31'd0, tx_valid}, 0);

    // R7 / R8 same-cycle events on a full receive FIFO
    for (int i = 0; i < 64; i++) begin
      rx_q.push_back(8'(i + 8'h80));
      rx_send(8'(i + 8'h80));
    end
    bus_read(5, d); check("R7 rx full no overrun", d, 32'h21);
    read_with_rx(0, 8'hEE, d);
    check("R7 pop with push on full", d, {24'd0, rx_q.pop_front()});
    rx_q.push_back(8'hEE);
    bus_read(5, d); check("R7 swap no overrun", d, 32'h21);
    read_with_rx(5, 8'h77, d);
    check("R8 read returns old overrun", d, 32'h21);
    bus_read(5, d); check("R8 set wins over clear", d, 32'h23);
    bus_read(5, d); check("R8 cleared next read", d, 32'h21);
    for (int i = 0; i < 64; i++) begin
      bus_read(0, d);
      check("R2 drain order", d, {24'd0, rx_q.pop_front()});
    end
    bus_read(5, d); check("R2 drained", d, 32'h20);

    done = 1;
    summary();
    $finish;
  end
endmodule